// File: doc/BRIEF.md
# Dual-Polynomial Data Randomizer

This block whitens a transmit data stream by XORing each data bit with the output of a linear feedback shift register (LFSR). At run time a configuration bit picks one of two generators: a 6-stage register with feedback polynomial x^6 + x^5 + 1, or a 15-stage register with polynomial x^15 + x^14 + 1. At every start-of-packet the register is loaded from a programmable seed, so each packet is randomized from a known starting point.

The stream is either bit-serial (one bit per valid beat on bit 0) or byte-wide (eight LFSR steps per beat, most significant bit first). The block treats every byte the same whether it carries plain payload or already-encoded check symbols. It can therefore sit on either side of an error-correction encoder. An enable bit turns the function into a plain register stage whose LFSR is frozen. The result appears one clock after the input beat, with a matching valid.

Top module: `dpr_scrambler`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. `out_data` changes only on the clock after a valid beat and holds its value otherwise. Reset (active-low `rst_n`, asynchronous) clears `out_valid`, `out_data` and the LFSR state to zero.
- R2: With `cfg_poly_long`=0 the keystream comes from a 6-bit state s[5:0]. Each step produces k = s[5]^s[4] and then sets s = {s[4:0], k}. The output bit is the data bit XOR k.
- R3: With `cfg_poly_long`=1 the keystream comes from a 15-bit state s[14:0]. Each step produces k = s[14]^s[13] and then sets s = {s[13:0], k}.
- R4: A valid beat with `in_sop`=1 and `cfg_enable`=1 starts from `cfg_seed` instead of the stored state, within that same beat. In 6-stage mode only `cfg_seed[5:0]` is used and bits [14:6] have no effect.
- R5: With `cfg_byte_mode`=1 each valid beat applies 8 steps. The first step's k is XORed into `in_data[7]` and the eighth into `in_data[0]`.
- R6: With `cfg_byte_mode`=0 each valid beat applies one step to `in_data[0]`. Bits [7:1] of `in_data` are ignored and `out_data[7:1]` is 0.
- R7: With `cfg_enable`=0 a valid beat passes through unchanged (all 8 bits in byte mode, bit 0 in bit mode). The LFSR state neither advances nor reloads, even on `in_sop`. A later enabled beat without `in_sop` continues from the frozen state.
- R8: An all-zero seed (all 15 bits in long mode, the low 6 bits in short mode) gives an all-zero keystream, so data passes unchanged for the rest of that packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | 1 = randomize, 0 = pass through with frozen LFSR |
| cfg_poly_long | input | 1 | 0 = 6-stage generator, 1 = 15-stage generator |
| cfg_byte_mode | input | 1 | 1 = 8 bits per beat, 0 = 1 bit per beat on bit 0 |
| cfg_seed | input | 15 | Starting state loaded at start-of-packet |
| in_valid | input | 1 | Input beat qualifier |
| in_sop | input | 1 | First beat of a packet |
| in_data | input | 8 | Input data |
| out_valid | output | 1 | Output beat qualifier |
| out_data | output | 8 | Randomized data |

## Verification
Every result is due exactly one clock edge after the beat that causes it. The bench drives each beat on a falling edge and checks the previous beat's output on the next falling edge, just before it drives the following beat. A held output after an idle beat, and a frozen state after a disabled beat, are read one edge later at the ports in the same way. For the continuation cases the bench keeps its own running model state across beats and packets. It does not infer the state from the output a cycle later.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    localparam int BYTE_W    = 8;
    localparam int SHORT_LEN = 6;
    localparam int LONG_LEN  = 15;
    localparam int SHORT_TAP_HI = SHORT_LEN - 1;
    localparam int SHORT_TAP_LO = SHORT_LEN - 2;
    localparam int LONG_TAP_HI  = LONG_LEN - 1;
    localparam int LONG_TAP_LO  = LONG_LEN - 2;
    localparam int PAD_LEN      = LONG_LEN - SHORT_LEN;

    typedef struct packed {
        logic                vld;
        logic [BYTE_W-1:0]   data;
        logic [LONG_LEN-1:0] state;
    } dpr_reg_t;
endpackage

// File: rtl/dpr_lfsr_stepper.sv
module dpr_lfsr_stepper #(
    parameter int LEN    = 6,
    parameter int STEPS  = 8,
    parameter int TAP_HI = 5,
    parameter int TAP_LO = 4
) (
    input  logic [LEN-1:0]   st_i,
    output logic [STEPS-1:0] ks_o,
    output logic [LEN-1:0]   st_one_o,
    output logic [LEN-1:0]   st_all_o
);
    logic [LEN-1:0] chain [0:STEPS];
    logic [STEPS-1:0] fb;

    assign chain[0] = st_i;

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        assign fb[g]       = chain[g][TAP_HI] ^ chain[g][TAP_LO];
        assign chain[g+1]  = {chain[g][LEN-2:0], fb[g]};
    end

    assign ks_o     = fb;
    assign st_one_o = chain[1];
    assign st_all_o = chain[STEPS];
endmodule

// File: rtl/dpr_lane_mixer.sv
module dpr_lane_mixer #(
    parameter int W = 8
) (
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] ks_i,
    input  logic         en_i,
    input  logic         byte_i,
    output logic [W-1:0] data_o
);
    always_comb begin
        data_o = '0;
        if (byte_i) begin
            for (int i = 0; i < W; i++) begin
                data_o[W-1-i] = data_i[W-1-i] ^ (en_i & ks_i[i]);
            end
        end else begin
            data_o[0] = data_i[0] ^ (en_i & ks_i[0]);
        end
    end
endmodule

// File: rtl/dpr_scrambler.sv
module dpr_scrambler
    import dpr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_enable,
    input  logic                cfg_poly_long,
    input  logic                cfg_byte_mode,
    input  logic [LONG_LEN-1:0] cfg_seed,
    input  logic                in_valid,
    input  logic                in_sop,
    input  logic [BYTE_W-1:0]   in_data,
    output logic                out_valid,
    output logic [BYTE_W-1:0]   out_data
);
    dpr_reg_t r_q, r_d;

    logic [LONG_LEN-1:0]  seed_eff;
    logic [LONG_LEN-1:0]  start_st;
    logic [BYTE_W-1:0]    ks_short, ks_long, ks_sel;
    logic [SHORT_LEN-1:0] s_one, s_all;
    logic [LONG_LEN-1:0]  l_one, l_all;
    logic [LONG_LEN-1:0]  next_st;
    logic [BYTE_W-1:0]    mixed;

    // Short mode keeps only the low seed bits (R4)
    assign seed_eff = cfg_poly_long ? cfg_seed
                                    : {{PAD_LEN{1'b0}}, cfg_seed[SHORT_LEN-1:0]};
    assign start_st = in_sop ? seed_eff : r_q.state;

    dpr_lfsr_stepper #(
        .LEN(SHORT_LEN), .STEPS(BYTE_W),
        .TAP_HI(SHORT_TAP_HI), .TAP_LO(SHORT_TAP_LO)
    ) u_short (
        .st_i     (start_st[SHORT_LEN-1:0]),
        .ks_o     (ks_short),
        .st_one_o (s_one),
        .st_all_o (s_all)
    );

    dpr_lfsr_stepper #(
        .LEN(LONG_LEN), .STEPS(BYTE_W),
        .TAP_HI(LONG_TAP_HI), .TAP_LO(LONG_TAP_LO)
    ) u_long (
        .st_i     (start_st),
        .ks_o     (ks_long),
        .st_one_o (l_one),
        .st_all_o (l_all)
    );

    always_comb begin
        ks_sel = cfg_poly_long ? ks_long : ks_short;
        if (cfg_poly_long) begin
            next_st = cfg_byte_mode ? l_all : l_one;
        end else begin
            next_st = cfg_byte_mode ? {{PAD_LEN{1'b0}}, s_all}
                                    : {{PAD_LEN{1'b0}}, s_one};
        end
    end

    dpr_lane_mixer #(.W(BYTE_W)) u_mix (
        .data_i (in_data),
        .ks_i   (ks_sel),
        .en_i   (cfg_enable),
        .byte_i (cfg_byte_mode),
        .data_o (mixed)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = in_valid;
        if (in_valid) begin
            r_d.data = mixed;
            if (cfg_enable) begin
                r_d.state = next_st;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.vld;
    assign out_data  = r_q.data;
endmodule

// File: rtl/dpr_scrambler_chk.sv
module dpr_scrambler_chk
    import dpr_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_enable,
    input logic                cfg_poly_long,
    input logic                cfg_byte_mode,
    input logic [LONG_LEN-1:0] cfg_seed,
    input logic                in_valid,
    input logic                in_sop,
    input logic [BYTE_W-1:0]   in_data,
    input logic                out_valid,
    input logic [BYTE_W-1:0]   out_data
);
    logic zero_seed;
    assign zero_seed = cfg_poly_long ? (cfg_seed == '0)
                                     : (cfg_seed[SHORT_LEN-1:0] == '0);

    p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    p_bit_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_byte_mode) |=> out_data[BYTE_W-1:1] == '0);

    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_enable && cfg_byte_mode) |=> out_data == $past(in_data));

    p_zero_seed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && cfg_enable && cfg_byte_mode && zero_seed)
        |=> out_data == $past(in_data));
endmodule

bind dpr_scrambler dpr_scrambler_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .cfg_poly_long(cfg_poly_long), .cfg_byte_mode(cfg_byte_mode),
    .cfg_seed(cfg_seed), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/dpr_scrambler_tb_top.sv
`timescale 1ns/1ps
module dpr_scrambler_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0, cfg_poly_long = 1'b0, cfg_byte_mode = 1'b0;
    logic [14:0] cfg_seed = '0;
    logic        in_valid = 1'b0, in_sop = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic [7:0]  out_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dpr_scrambler dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_poly_long(cfg_poly_long), .cfg_byte_mode(cfg_byte_mode),
        .cfg_seed(cfg_seed), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    // row = {valid, en, poly_long, byte_mode, sop, seed[14:0], data[7:0]}
    localparam int NV = 17;
    localparam logic [27:0] VEC [NV] = '{
        {5'b11011, 15'h0015, 8'hA5},   // short byte, new packet
        {5'b11010, 15'h0000, 8'h3C},
        {5'b11010, 15'h0000, 8'hFF},
        {5'b01010, 15'h0000, 8'h77},   // idle beat: hold
        {5'b11111, 15'h5A3C, 8'h00},   // long byte, new packet
        {5'b11110, 15'h0000, 8'h12},
        {5'b10111, 15'h1234, 8'hC3},   // disabled, sop must not reload
        {5'b10110, 15'h0000, 8'h81},
        {5'b11110, 15'h0000, 8'h00},   // continues frozen state
        {5'b11101, 15'h7001, 8'h01},   // long bit mode
        {5'b11100, 15'h0000, 8'hFE},
        {5'b11100, 15'h0000, 8'h01},
        {5'b11011, 15'h0000, 8'h5A},   // short zero seed
        {5'b11111, 15'h0000, 8'h99},   // long zero seed
        {5'b11001, 15'h7FC9, 8'h00},   // short bit mode, high seed bits set
        {5'b11010, 15'h0000, 8'h00},
        {5'b01010, 15'h0000, 8'h00}    // flush
    };

    logic [14:0] m_st = '0;
    logic        pend = 0;
    logic        exp_v = 0;
    logic [7:0]  exp_d = '0;
    string       exp_tag = "R1";

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [27:0] row);
        logic v, en, pl, bm, sp;
        logic [14:0] sd, st;
        logic [7:0] d, o;
        logic fb;
        int n;
        {v, en, pl, bm, sp, sd, d} = row;
        @(negedge clk);
        if (pend) begin
            check({exp_tag, " valid"}, {7'b0, out_valid}, {7'b0, exp_v});
            check(exp_tag, out_data, exp_d);
        end
        in_valid = v; cfg_enable = en; cfg_poly_long = pl; cfg_byte_mode = bm;
        in_sop = sp; cfg_seed = sd; in_data = d;
        pend = 1;
        exp_v = v;
        if (!v) begin
            exp_tag = "R1";
            return;
        end
        o = bm ? d : {7'b0, d[0]};
        if (en) begin
            st = sp ? (pl ? sd : {9'b0, sd[5:0]}) : m_st;
            n = bm ? 8 : 1;
            for (int k = 0; k < n; k++) begin
                fb = pl ? (st[14] ^ st[13]) : (st[5] ^ st[4]);
                st = pl ? {st[13:0], fb} : {9'b0, st[4:0], fb};
                if (bm) o[7-k] = o[7-k] ^ fb;
                else    o[0]   = o[0] ^ fb;
            end
            m_st = st;
        end
        exp_d = o;
        if (!en) exp_tag = "R7";
        else if (sp && (pl ? sd == 0 : sd[5:0] == 0)) exp_tag = "R8";
        else if (!bm) exp_tag = "R6";
        else if (pl) exp_tag = "R3";
        else exp_tag = "R2";
    endtask

    function automatic logic [27:0] mk(input logic [4:0] f, input logic [14:0] s, input logic [7:0] d);
        return {f, s, d};
    endfunction

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset valid", {7'b0, out_valid}, 8'h00);
        check("R1 reset data", out_data, 8'h00);
        rst_n = 1'b1;

        // Vector walk against the bench model
        for (int i = 0; i < NV; i++) step(VEC[i]);

        // R2/R5: short seed 1, byte 00 -> 0C (MSB takes first step)
        step(mk(5'b11011, 15'h0001, 8'h00));
        step(mk(5'b01010, 15'h0000, 8'h00));
        check("R2 R5 short hand value", out_data, 8'h0C);

        // R4: upper seed bits ignored in short mode
        step(mk(5'b11011, 15'h7FC1, 8'h00));
        step(mk(5'b01010, 15'h0000, 8'h00));
        check("R4 short seed upper bits", out_data, 8'h0C);

        // R3: long seed 4000 -> 80, then 03
        step(mk(5'b11111, 15'h4000, 8'h00));
        step(mk(5'b11110, 15'h0000, 8'h00));
        check("R3 long first byte", out_data, 8'h80);
        step(mk(5'b01110, 15'h0000, 8'h00));
        check("R3 long second byte", out_data, 8'h03);

        // R7: disabled beats with sop, then continue: third byte same as w/o gap
        step(mk(5'b11111, 15'h4000, 8'h00));
        step(mk(5'b10111, 15'h0001, 8'h5D));
        check("R3 long first byte again", out_data, 8'h80);
        step(mk(5'b11110, 15'h0000, 8'h00));
        check("R7 bypass data", out_data, 8'h5D);
        step(mk(5'b01110, 15'h0000, 8'h00));
        check("R7 frozen state resumes", out_data, 8'h03);

        // R6: bit mode ignores upper bits
        step(mk(5'b11001, 15'h0001, 8'hFE));
        step(mk(5'b01000, 15'h0000, 8'h00));
        check("R6 bit mode upper bits", out_data, 8'h00);

        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule